// File: doc/BRIEF.md
# Privileged Region Address Mapping Buffer

This block translates virtual addresses in the two privileged kernel regions of a 32-bit processor (the cached one and the uncached one, both carrying virtual bits 31:30 = 2'b10) into 32-bit physical addresses. Software fills a 16-entry, fully associative table. Each entry holds an 8-bit virtual tag, an 8-bit physical tag, a page-size code and three memory attributes. A lookup compares the top byte of the virtual address against every valid entry at once, using each entry's own page size. It returns the physical address, the cacheable, unbuffered and write-through attributes, and a miss or multi-hit indication.

Translation takes place only after software has set the extended-address mode. Out of reset the block runs in legacy mode. In that mode every lookup bypasses the table and the upper three address bits are cleared. In extended mode, addresses outside the two privileged regions are flagged as belonging to the other translation path and returned unchanged. The lookup result is registered by default, one cycle after the request, and a parameter selects a purely combinational result instead.

Top module: `priv_map_buf`

## Requirements
- R1: After reset `ext_mode` is 0 and every entry reads back with its valid bit (bit 21 of the entry word) cleared.
- R2: A pulse on `mode_wr_en` loads `mode_wr_val` into `ext_mode` at the next clock. While `ext_mode` is 0 a lookup returns `lk_bypass`=1 and `lk_paddr` = {3'b000, vaddr[28:0]}, with hit, miss, multi-hit, other and all attributes at 0.
- R3: Entry word layout is [21]=valid, [20:13]=virtual tag, [12:5]=physical tag, [4:3]=size, [2]=cacheable, [1]=unbuffered, [0]=write-through. A write at index `ent_wr_idx` is visible on `ent_rd_word` for `ent_rd_idx` from the next clock.
- R4: In extended mode a virtual address with bits 31:30 not equal to 2'b10 gives `lk_other`=1 and `lk_paddr` equal to the virtual address, with hit and miss at 0.
- R5: An entry matches when it is valid, its virtual tag bits 7:6 are 2'b10, and its virtual tag equals vaddr[31:24] on every bit at or above its page boundary.
- R6: Size codes are 00 = 16 MB, 01 = 64 MB, 10 = 128 MB, 11 = 512 MB. On a hit, physical bits at or above the page boundary come from the physical tag, and all lower bits come from the virtual address.
- R7: On a hit `lk_c`, `lk_ub` and `lk_wt` equal the cacheable, unbuffered and write-through bits of the entry used.
- R8: A privileged-region lookup with no matching entry gives `lk_miss`=1, `lk_paddr`=0 and all attributes 0.
- R9: When more than one entry matches, `lk_multi`=1 and the lowest-numbered matching entry supplies address and attributes.
- R10: With REG_OUT=1, the result and `lk_vld` appear one clock after `lk_req`. A lookup in the same cycle as a write to the matching entry uses the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_en | input | 1 | Write strobe for the extended-mode flag |
| mode_wr_val | input | 1 | Value written to the extended-mode flag |
| ext_mode | output | 1 | Current extended-mode flag |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_idx | input | 4 | Entry write index |
| ent_wr_word | input | 22 | Entry contents to write |
| ent_rd_idx | input | 4 | Entry read index |
| ent_rd_word | output | 22 | Stored contents of the addressed entry |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_vld | output | 1 | Lookup result valid |
| lk_paddr | output | 32 | Physical address |
| lk_hit | output | 1 | An entry matched |
| lk_miss | output | 1 | Privileged-region address with no match |
| lk_multi | output | 1 | More than one entry matched |
| lk_bypass | output | 1 | Legacy mode, table not used |
| lk_other | output | 1 | Address outside the privileged regions |
| lk_c | output | 1 | Cacheable attribute |
| lk_ub | output | 1 | Unbuffered attribute |
| lk_wt | output | 1 | Write-through attribute |

## Verification
The hardest case to reach is a multi-hit. Entries written in the normal way can overlap only when a large page covers the tag of a smaller one. The stimulus programs a 512 MB entry at a low index and both a 16 MB entry inside it and a 16 MB entry in the top slot of the table. Lookups in the overlap must then pick the low-numbered entry. The write-versus-lookup collision is driven in a single cycle that rewrites the matching entry's physical tag, and a second lookup afterwards confirms the new tag.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

    localparam int VA_W  = 32;
    localparam int TAG_W = 8;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] vtag;
        logic [TAG_W-1:0] ptag;
        logic [1:0]       sz;
        logic             cach;
        logic             ubuf;
        logic             wthru;
    } pmb_ent_t;

    localparam int ENT_W = $bits(pmb_ent_t);

    typedef struct packed {
        logic            vld;
        logic [VA_W-1:0] paddr;
        logic            hit;
        logic            miss;
        logic            multi;
        logic            bypass;
        logic            other;
        logic            cach;
        logic            ubuf;
        logic            wthru;
    } lk_res_t;

    // Tag bits kept from the entry (at or above the page boundary)
    function automatic logic [TAG_W-1:0] size_mask(logic [1:0] sz);
        case (sz)
            2'b00:   return 8'hFF;  // 16 MB
            2'b01:   return 8'hFC;  // 64 MB
            2'b10:   return 8'hF8;  // 128 MB
            default: return 8'hE0;  // 512 MB
        endcase
    endfunction

endpackage

// File: rtl/pmb_tag_cmp.sv
module pmb_tag_cmp
    import pmb_pkg::*;
(
    input  pmb_ent_t         ent,
    input  logic [TAG_W-1:0] va_tag,
    output logic             match
);
    logic [TAG_W-1:0] keep;
    logic             region_ok;

    always_comb begin
        keep      = size_mask(ent.sz);
        region_ok = (ent.vtag[TAG_W-1:TAG_W-2] == 2'b10);
        match     = ent.vld && region_ok && (((ent.vtag ^ va_tag) & keep) == '0);
    end
endmodule

// File: rtl/pmb_hit_sel.sv
module pmb_hit_sel #(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] match,
    output logic               hit,
    output logic               multi,
    output logic [IDX_W-1:0]   sel_idx
);
    always_comb begin
        hit     = 1'b0;
        multi   = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (match[i]) begin
                if (hit) begin
                    multi = 1'b1;
                end else begin
                    hit     = 1'b1;
                    sel_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/pmb_form.sv
module pmb_form
    import pmb_pkg::*;
(
    input  logic             ext_mode,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             hit,
    input  logic             multi,
    input  logic [TAG_W-1:0] ptag,
    input  logic [1:0]       sz,
    input  logic             cach,
    input  logic             ubuf,
    input  logic             wthru,
    output lk_res_t          res
);
    logic [TAG_W-1:0] keep;
    logic [TAG_W-1:0] top_byte;

    always_comb begin
        keep     = size_mask(sz);
        top_byte = (ptag & keep) | (vaddr[VA_W-1:VA_W-TAG_W] & ~keep);
        res      = '0;
        if (!ext_mode) begin
            res.bypass = 1'b1;
            res.paddr  = {3'b000, vaddr[VA_W-4:0]};
        end else if (vaddr[VA_W-1:VA_W-2] != 2'b10) begin
            res.other = 1'b1;
            res.paddr = vaddr;
        end else if (hit) begin
            res.hit   = 1'b1;
            res.multi = multi;
            res.paddr = {top_byte, vaddr[VA_W-TAG_W-1:0]};
            res.cach  = cach;
            res.ubuf  = ubuf;
            res.wthru = wthru;
        end else begin
            res.miss = 1'b1;
        end
    end
endmodule

// File: rtl/priv_map_buf.sv
module priv_map_buf
    import pmb_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr_en,
    input  logic             mode_wr_val,
    output logic             ext_mode,
    input  logic             ent_wr_en,
    input  logic [IDX_W-1:0] ent_wr_idx,
    input  logic [ENT_W-1:0] ent_wr_word,
    input  logic [IDX_W-1:0] ent_rd_idx,
    output logic [ENT_W-1:0] ent_rd_word,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_vld,
    output logic [VA_W-1:0]  lk_paddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_multi,
    output logic             lk_bypass,
    output logic             lk_other,
    output logic             lk_c,
    output logic             lk_ub,
    output logic             lk_wt
);
    typedef struct packed {
        logic                      ext_mode;
        pmb_ent_t [NUM_ENT-1:0]    ents;
        lk_res_t                   res;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_ENT-1:0] match;
    logic               any_hit;
    logic               multi_hit;
    logic [IDX_W-1:0]   sel_idx;
    lk_res_t            res_c;
    lk_res_t            res_o;

    // Per-entry comparators
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        pmb_tag_cmp u_cmp (
            .ent    (st_q.ents[g]),
            .va_tag (lk_vaddr[VA_W-1:VA_W-TAG_W]),
            .match  (match[g])
        );
    end

    pmb_hit_sel #(.NUM_ENT(NUM_ENT)) u_sel (
        .match   (match),
        .hit     (any_hit),
        .multi   (multi_hit),
        .sel_idx (sel_idx)
    );

    pmb_form u_form (
        .ext_mode (st_q.ext_mode),
        .vaddr    (lk_vaddr),
        .hit      (any_hit),
        .multi    (multi_hit),
        .ptag     (st_q.ents[sel_idx].ptag),
        .sz       (st_q.ents[sel_idx].sz),
        .cach     (st_q.ents[sel_idx].cach),
        .ubuf     (st_q.ents[sel_idx].ubuf),
        .wthru    (st_q.ents[sel_idx].wthru),
        .res      (res_c)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (mode_wr_en) begin
            st_d.ext_mode = mode_wr_val;
        end
        if (ent_wr_en) begin
            st_d.ents[ent_wr_idx] = pmb_ent_t'(ent_wr_word);
        end
        st_d.res     = res_c;
        st_d.res.vld = lk_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Result timing variant
    if (REG_OUT) begin : g_reg
        assign res_o = st_q.res;
    end else begin : g_comb
        always_comb begin
            res_o     = res_c;
            res_o.vld = lk_req;
        end
    end

    assign ext_mode    = st_q.ext_mode;
    assign ent_rd_word = st_q.ents[ent_rd_idx];
    assign lk_vld      = res_o.vld;
    assign lk_paddr    = res_o.paddr;
    assign lk_hit      = res_o.hit;
    assign lk_miss     = res_o.miss;
    assign lk_multi    = res_o.multi;
    assign lk_bypass   = res_o.bypass;
    assign lk_other    = res_o.other;
    assign lk_c        = res_o.cach;
    assign lk_ub       = res_o.ubuf;
    assign lk_wt       = res_o.wthru;
endmodule

// File: rtl/pmb_chk.sv
module pmb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_wr_en,
    input logic        mode_wr_val,
    input logic        ext_mode,
    input logic        lk_vld,
    input logic [31:0] lk_paddr,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic        lk_multi,
    input logic        lk_bypass,
    input logic        lk_other,
    input logic        lk_c,
    input logic        lk_ub,
    input logic        lk_wt
);
    a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> (ext_mode == $past(mode_wr_val)));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_en |=> $stable(ext_mode));

    a_r2_bypass_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && lk_bypass) |-> (lk_paddr[31:29] == 3'b000 && !lk_hit && !lk_miss));

    a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && lk_miss) |-> (lk_paddr == 32'h0 && !lk_c && !lk_ub && !lk_wt));

    a_r9_multi_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_vld |-> ($countones({lk_hit, lk_miss, lk_bypass, lk_other}) == 1));
endmodule

bind priv_map_buf pmb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr_en  (mode_wr_en),
    .mode_wr_val (mode_wr_val),
    .ext_mode    (ext_mode),
    .lk_vld      (lk_vld),
    .lk_paddr    (lk_paddr),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_multi    (lk_multi),
    .lk_bypass   (lk_bypass),
    .lk_other    (lk_other),
    .lk_c        (lk_c),
    .lk_ub       (lk_ub),
    .lk_wt       (lk_wt)
);

// File: tb/sim_priv_map_buf.sv
`timescale 1ns/1ps
module sim_priv_map_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr_en = 1'b0, mode_wr_val = 1'b0, ext_mode;
    logic        ent_wr_en = 1'b0;
    logic [3:0]  ent_wr_idx = '0, ent_rd_idx = '0;
    logic [21:0] ent_wr_word = '0, ent_rd_word;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0, lk_paddr;
    logic        lk_vld, lk_hit, lk_miss, lk_multi, lk_bypass, lk_other, lk_c, lk_ub, lk_wt;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    priv_map_buf u0 (.*);

    // {vaddr, paddr, hit, miss, multi, other, c, ub, wt}
    localparam int NV = 11;
    localparam logic [70:0] VEC [NV] = '{
        {32'h80ABCDEF, 32'h12ABCDEF, 7'b1000_100},
        {32'h86001234, 32'h42001234, 7'b1000_010},
        {32'hB5000001, 32'hF5000001, 7'b1000_101},
        {32'hA8000010, 32'hE8000010, 7'b1010_101},
        {32'h90000000, 32'h00000000, 7'b0100_000},
        {32'h8B123456, 32'hFB123456, 7'b1000_011},
        {32'h98000010, 32'hFD000010, 7'b1000_000},
        {32'h30000000, 32'h30000000, 7'b0001_000},
        {32'hC0000000, 32'hC0000000, 7'b0001_000},
        {32'h8C000000, 32'hFC000000, 7'b1000_011},
        {32'hBF000000, 32'hFF000000, 7'b1010_101}
    };

    function automatic logic [21:0] mk(bit v, logic [7:0] vt, logic [7:0] pt,
                                      logic [1:0] sz, bit c, bit ub, bit wt);
        return {v, vt, pt, sz, c, ub, wt};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ent(int idx, logic [21:0] w);
        @(negedge clk);
        ent_wr_en = 1'b1; ent_wr_idx = 4'(idx); ent_wr_word = w;
        @(negedge clk);
        ent_wr_en = 1'b0;
    endtask

    task automatic set_mode(bit v);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_val = v;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    // Request at a negedge; registered result sampled at the next negedge
    task automatic lookup(logic [31:0] va);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic all_clear;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ext_mode == 1'b0, "R1 mode", 64'(ext_mode), 64'd0);
        all_clear = 1'b1;
        for (int i = 0; i < 16; i++) begin
            ent_rd_idx = 4'(i);
            #1;
            if (ent_rd_word[21]) all_clear = 1'b0;
        end
        chk(all_clear, "R1 valid bits", 64'(all_clear), 64'd1);

        // R3: write then read back
        wr_ent(0, mk(1, 8'h80, 8'h12, 2'b00, 1, 0, 0));
        ent_rd_idx = 4'd0; #1;
        chk(ent_rd_word == mk(1, 8'h80, 8'h12, 2'b00, 1, 0, 0), "R3 readback",
            64'(ent_rd_word), 64'(mk(1, 8'h80, 8'h12, 2'b00, 1, 0, 0)));
        wr_ent(1,  mk(1, 8'h84, 8'h40, 2'b01, 0, 1, 0));
        wr_ent(2,  mk(1, 8'hA0, 8'hE0, 2'b11, 1, 0, 1));
        wr_ent(3,  mk(1, 8'hA8, 8'h55, 2'b00, 0, 0, 0));
        wr_ent(5,  mk(0, 8'h90, 8'h77, 2'b00, 1, 1, 1));
        wr_ent(6,  mk(1, 8'h88, 8'hFC, 2'b10, 0, 1, 1));
        wr_ent(7,  mk(1, 8'h98, 8'hFD, 2'b00, 0, 0, 0));
        wr_ent(15, mk(1, 8'hBF, 8'h01, 2'b00, 0, 0, 0));

        // R2: legacy mode bypass even with entries present
        lookup(32'hA8000010);
        chk(lk_vld && lk_bypass && !lk_hit && !lk_miss && !lk_other, "R2 bypass flags",
            64'({lk_vld, lk_bypass, lk_hit, lk_miss, lk_other}), 64'b11000);
        chk(lk_paddr == 32'h08000010, "R2 bypass addr", 64'(lk_paddr), 64'h08000010);

        set_mode(1'b1);
        chk(ext_mode == 1'b1, "R2 mode set", 64'(ext_mode), 64'd1);

        // Table walk: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [31:0] va, pa;
            logic [6:0]  fl;
            string       tag;
            {va, pa, fl} = VEC[i];
            tag = fl[5] ? "R8" : (fl[4] ? "R9" : (fl[3] ? "R4" : "R6"));
            lookup(va);
            chk(lk_paddr == pa, tag, 64'(lk_paddr), 64'(pa));
            chk({lk_hit, lk_miss, lk_multi, lk_other} == fl[6:3], tag,
                64'({lk_hit, lk_miss, lk_multi, lk_other}), 64'(fl[6:3]));
            chk({lk_c, lk_ub, lk_wt} == fl[2:0], "R7 attributes",
                64'({lk_c, lk_ub, lk_wt}), 64'(fl[2:0]));
        end

        // R10: latency - result valid exactly one clock after request
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = 32'h80000004;
        #1;
        chk(lk_vld == 1'b0, "R10 not yet valid", 64'(lk_vld), 64'd0);
        @(negedge clk);
        lk_req = 1'b0;
        chk(lk_vld == 1'b1, "R10 valid after one clock", 64'(lk_vld), 64'd1);

        // R10: same-cycle write to the matching entry sees old contents
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = 32'h80000020;
        ent_wr_en = 1'b1; ent_wr_idx = 4'd0; ent_wr_word = mk(1, 8'h80, 8'h33, 2'b00, 1, 0, 0);
        @(negedge clk);
        lk_req = 1'b0; ent_wr_en = 1'b0;
        chk(lk_paddr == 32'h12000020, "R10 old contents", 64'(lk_paddr), 64'h12000020);
        lookup(32'h80000020);
        chk(lk_paddr == 32'h33000020, "R10 new contents", 64'(lk_paddr), 64'h33000020);

        // R5: clearing valid makes the entry stop matching
        wr_ent(7, mk(0, 8'h98, 8'hFD, 2'b00, 0, 0, 0));
        lookup(32'h98000010);
        chk(lk_miss && !lk_hit, "R5 invalid entry", 64'({lk_miss, lk_hit}), 64'b10);

        // R2: return to legacy mode
        set_mode(1'b0);
        lookup(32'hFFFFFFFF);
        chk(lk_bypass && lk_paddr == 32'h1FFFFFFF, "R2 legacy again",
            64'(lk_paddr), 64'h1FFFFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule